// File: doc/BRIEF.md
# Compare PWM with resolution select

This block drives one pulse-width-modulated output pin. A free-running frame counter advances once per PWM clock. Each frame starts with the pin high, and the pin stays high while the counter is below a compare value. The frame then runs to its end with the pin low. The PWM clock is the system clock divided by a power of two between 16 and 128.

A resolution select bit picks the frame length. Full resolution gives a 256-count frame. Narrow resolution gives a 32-count frame, and only the low five data bits count. Software writes a staging data register. Its value moves into the compare register only when the frame counter wraps, so a write never shortens or lengthens a pulse that has already started. A host reaches the block through plain write strobes for the control and data registers, plus a control readback bus.

Top module: `pwm_res_chan`

## Requirements
- R1: After a synchronous reset the pin is low, the control readback is 0x00 and the data value is 0, so the pin stays low until software writes a nonzero value.
- R2: Control bits [1:0] select the prescaler. The PWM clock period is 16 << bits[1:0] system clocks, that is 16, 32, 64 or 128.
- R3: The control register keeps bits [2:0] as written. Bits [7:3] are ignored on write and read back as 0.
- R4: When control bit 2 is 1 (narrow mode), only data bits [4:0] set the pulse width, and data bits [7:5] have no effect on the pin.
- R5: A frame is 256 PWM clocks in full mode (control bit 2 = 0) and 32 PWM clocks in narrow mode. The pin therefore repeats every (16 << bits[1:0]) × frame-length system clocks.
- R6: Within each frame the pin is high for exactly D PWM clocks, starting at the frame start, where D is the effective data value. D = 0 keeps the pin constantly low.
- R7: A data write made in the middle of a frame does not alter that frame. The new value takes effect from the next frame start.
- R8: Asserting reset while the channel is running forces the pin low and clears control and data at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control write data: [1:0] prescaler select, [2] narrow mode |
| data_we | input | 1 | Write strobe for the staging data register |
| data_wdata | input | 8 | Pulse width value |
| ctl_rdata | output | 8 | Control readback, bits [7:3] always 0 |
| pwm_out | output | 1 | PWM output pin |

## Verification
A prescaler that ticks at the wrong rate, or a frame counter that wraps at the wrong count, stretches or shrinks the period between rising edges of the pin. A fault of this kind shows within two frames. A compare register loaded with unmasked data, or with no masking at all, gives the wrong high-time count over one full period in narrow mode. A compare register that loads outside the wrap changes the length of the pulse that is in progress. That fault shows on the very frame in which the write lands.

// File: rtl/pwm_res_pkg.sv
package pwm_res_pkg;

  localparam int DATA_W    = 8;
  localparam int NARROW_W  = 5;
  localparam int PFS_W     = 2;
  localparam int BASE_LOG2 = 4;
  localparam int CTL_W     = 8;

  localparam int PFS_LSB   = 0;
  localparam int SEL_BIT   = PFS_LSB + PFS_W;

  typedef struct packed {
    logic             narrow;
    logic [PFS_W-1:0] pfs;
  } pwm_cfg_t;

  // Readback image of the control register: unused bits are zero.
  function automatic logic [CTL_W-1:0] ctl_image(pwm_cfg_t c);
    logic [CTL_W-1:0] r;
    r = '0;
    r[PFS_LSB +: PFS_W] = c.pfs;
    r[SEL_BIT]          = c.narrow;
    return r;
  endfunction

  // Decode of a written control byte into the stored configuration.
  function automatic pwm_cfg_t ctl_decode(logic [CTL_W-1:0] w);
    pwm_cfg_t c;
    c.pfs    = w[PFS_LSB +: PFS_W];
    c.narrow = w[SEL_BIT];
    return c;
  endfunction

endpackage

// File: rtl/pwm_res_regs.sv
module pwm_res_regs
  import pwm_res_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CTL_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ctl_we,
  input  logic [CW-1:0] ctl_wdata,
  input  logic          data_we,
  input  logic [DW-1:0] data_wdata,
  output pwm_cfg_t      cfg,
  output logic [DW-1:0] data_stage,
  output logic [CW-1:0] ctl_rdata
);

  pwm_cfg_t      cfg_q;
  logic [DW-1:0] stage_q;
  logic          ctl_hi_unused;

  assign ctl_hi_unused = ^ctl_wdata[CW-1:SEL_BIT+1];

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q   <= '0;
      stage_q <= '0;
    end else begin
      if (ctl_we)  cfg_q   <= ctl_decode(ctl_wdata);
      if (data_we) stage_q <= data_wdata;
    end
  end

  assign cfg        = cfg_q;
  assign data_stage = stage_q;
  assign ctl_rdata  = ctl_image(cfg_q);

  // R3
  ctl_keep_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_we |=> (ctl_rdata[SEL_BIT:0] == $past(ctl_wdata[SEL_BIT:0])));

endmodule

// File: rtl/pwm_res_presc.sv
module pwm_res_presc #(
  parameter int PW    = 2,
  parameter int BASE  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pfs,
  output logic          tick
);

  localparam int MAX_SH = (1 << PW) - 1;
  localparam int CNT_W  = BASE + MAX_SH;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  // Last count of one PWM clock: (2^BASE << sel) - 1.
  function automatic logic [CNT_W-1:0] div_last(logic [PW-1:0] sel);
    logic [CNT_W-1:0] ones;
    ones = '1;
    return ones >> (MAX_SH - int'(sel));
  endfunction

  assign lim  = div_last(pfs);
  // >= so that a smaller ratio chosen mid-count still ticks at once.
  assign tick = (cnt_q >= lim);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + CNT_W'(1);
  end

  // R2
  tick_gap_chk: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/pwm_res_frame.sv
module pwm_res_frame #(
  parameter int DW = 8,
  parameter int NW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          narrow,
  input  logic [DW-1:0] data_stage,
  output logic          wrap,
  output logic [DW-1:0] cmp_val,
  output logic          pwm_out
);

  localparam logic [DW-1:0] NARROW_LAST = DW'((1 << NW) - 1);
  localparam logic [DW-1:0] FULL_LAST   = '1;

  logic [DW-1:0] fcnt_q;
  logic [DW-1:0] cmp_q;
  logic [DW-1:0] frame_last;

  function automatic logic [DW-1:0] eff_data(logic [DW-1:0] d, logic nar);
    return nar ? (d & NARROW_LAST) : d;
  endfunction

  assign frame_last = narrow ? NARROW_LAST : FULL_LAST;
  // >= lets a switch from full to narrow mode end a long frame at once.
  assign wrap       = tick && (fcnt_q >= frame_last);

  always_ff @(posedge clk) begin
    if (rst) begin
      fcnt_q <= '0;
      cmp_q  <= '0;
    end else begin
      if (wrap) begin
        fcnt_q <= '0;
        cmp_q  <= eff_data(data_stage, narrow);
      end else if (tick) begin
        fcnt_q <= fcnt_q + DW'(1);
      end
    end
  end

  assign cmp_val = cmp_q;
  assign pwm_out = (fcnt_q < cmp_q);

  // R5
  wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (fcnt_q == '0));

  // R7
  cmp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(cmp_q));

  // R4
  narrow_cmp_chk: assert property (@(posedge clk) disable iff (rst)
    (wrap && narrow) |=> (cmp_q <= NARROW_LAST));

endmodule

// File: rtl/pwm_res_chan.sv
module pwm_res_chan
  import pwm_res_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  input  logic             data_we,
  input  logic [DATA_W-1:0] data_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  output logic             pwm_out
);

  pwm_cfg_t          cfg;
  logic [DATA_W-1:0] data_stage;
  logic              pwm_tick;
  logic              frame_wrap;
  logic [DATA_W-1:0] cmp_val;

  pwm_res_regs #(.DW(DATA_W), .CW(CTL_W)) u_regs (
    .clk        (clk),
    .rst        (rst),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .data_we    (data_we),
    .data_wdata (data_wdata),
    .cfg        (cfg),
    .data_stage (data_stage),
    .ctl_rdata  (ctl_rdata)
  );

  pwm_res_presc #(.PW(PFS_W), .BASE(BASE_LOG2)) u_presc (
    .clk  (clk),
    .rst  (rst),
    .pfs  (cfg.pfs),
    .tick (pwm_tick)
  );

  pwm_res_frame #(.DW(DATA_W), .NW(NARROW_W)) u_frame (
    .clk        (clk),
    .rst        (rst),
    .tick       (pwm_tick),
    .narrow     (cfg.narrow),
    .data_stage (data_stage),
    .wrap       (frame_wrap),
    .cmp_val    (cmp_val),
    .pwm_out    (pwm_out)
  );

  // R6
  zero_low_chk: assert property (@(posedge clk) disable iff (rst)
    (cmp_val == '0) |-> !pwm_out);

  // R5
  wrap_on_tick_chk: assert property (@(posedge clk) disable iff (rst)
    frame_wrap |=> !frame_wrap);

endmodule

// File: tb/pwm_res_chan_bench.sv
module pwm_res_chan_bench;

  logic       clk = 1'b0;
  logic       rst;
  logic       ctl_we;
  logic [7:0] ctl_wdata;
  logic       data_we;
  logic [7:0] data_wdata;
  logic [7:0] ctl_rdata;
  logic       pwm_out;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  pwm_res_chan u_pwm_res_chan (
    .clk        (clk),
    .rst        (rst),
    .ctl_we     (ctl_we),
    .ctl_wdata  (ctl_wdata),
    .data_we    (data_we),
    .data_wdata (data_wdata),
    .ctl_rdata  (ctl_rdata),
    .pwm_out    (pwm_out)
  );

  // {pfs[1:0], narrow, data[7:0], expected high clocks per period[15:0]}
  localparam int NV = 9;
  localparam logic [26:0] VEC [NV] = '{
    {2'd0, 1'b1, 8'd10,  16'd160},
    {2'd0, 1'b1, 8'h3F,  16'd496},
    {2'd0, 1'b1, 8'h20,  16'd0},
    {2'd1, 1'b1, 8'd5,   16'd160},
    {2'd3, 1'b1, 8'd16,  16'd2048},
    {2'd0, 1'b0, 8'h80,  16'd2048},
    {2'd0, 1'b0, 8'hFF,  16'd4080},
    {2'd2, 1'b1, 8'd3,   16'd192},
    {2'd0, 1'b0, 8'd0,   16'd0}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk);
    ctl_we = 1'b1; ctl_wdata = v;
    @(negedge clk);
    ctl_we = 1'b0;
  endtask

  task automatic wr_data(input logic [7:0] v);
    @(negedge clk);
    data_we = 1'b1; data_wdata = v;
    @(negedge clk);
    data_we = 1'b0;
  endtask

  task automatic count_high(input int n, output int h);
    h = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      if (pwm_out) h++;
    end
  endtask

  task automatic wait_rise();
    do @(negedge clk); while (pwm_out);
    do @(negedge clk); while (!pwm_out);
  endtask

  task automatic rise_gap(output int g);
    wait_rise();
    g = 0;
    do begin @(negedge clk); g++; end while (pwm_out);
    do begin @(negedge clk); g++; end while (!pwm_out);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int h, g, per, ratio, run;
    rst = 1'b1; ctl_we = 1'b0; ctl_wdata = '0; data_we = 1'b0; data_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    @(negedge clk);
    check(pwm_out == 1'b0, "R1 pin low", pwm_out, 0);
    check(ctl_rdata == 8'h00, "R1 ctl readback", ctl_rdata, 0);
    count_high(300, h);
    check(h == 0, "R1 pin stays low", h, 0);

    // Table walk: R2 R4 R5 R6
    for (int i = 0; i < NV; i++) begin
      logic [1:0]  vp;
      logic        vn;
      logic [7:0]  vd;
      logic [15:0] vh;
      {vp, vn, vd, vh} = VEC[i];
      ratio = 16 << vp;
      per   = ratio * (vn ? 32 : 256);
      wr_ctl({5'(i * 7 + 3), vn, vp});
      wr_data(vd);
      repeat (2 * per + 32) @(negedge clk);
      count_high(per, h);
      check(h == int'(vh), $sformatf("R6 R4 high time vec%0d", i), h, int'(vh));
      if (vh != 0 && int'(vh) < per) begin
        rise_gap(g);
        check(g == per, $sformatf("R2 R5 period vec%0d", i), g, per);
      end
    end

    // R7: write during a pulse leaves that frame alone
    wr_ctl(8'h04);
    wr_data(8'd8);
    repeat (2 * 512 + 32) @(negedge clk);
    wait_rise();
    run = 1;
    for (int k = 0; k < 1000; k++) begin
      @(negedge clk);
      if (k == 2) begin data_we = 1'b1; data_wdata = 8'd20; end
      if (k == 3) data_we = 1'b0;
      if (!pwm_out) break;
      run++;
    end
    check(run == 128, "R7 current frame keeps old width", run, 128);
    wait_rise();
    run = 1;
    do begin @(negedge clk); if (pwm_out) run++; end while (pwm_out);
    check(run == 320, "R7 next frame uses new width", run, 320);

    // R3: unused control bits
    wr_ctl(8'hFF);
    @(negedge clk);
    check(ctl_rdata == 8'h07, "R3 readback masks bits 7:3", ctl_rdata, 8'h07);
    wr_ctl(8'hF8);
    @(negedge clk);
    check(ctl_rdata == 8'h00, "R3 upper bits ignored", ctl_rdata, 0);

    // R8: reset while running
    wr_ctl(8'h04);
    wr_data(8'h1F);
    repeat (1100) @(negedge clk);
    wait_rise();
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check(pwm_out == 1'b0, "R8 pin low after reset", pwm_out, 0);
    check(ctl_rdata == 8'h00, "R8 ctl cleared", ctl_rdata, 0);
    count_high(5000, h);
    check(h == 0, "R8 data cleared, pin stays low", h, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule